// File: doc/BRIEF.md
# Pointer-Bank Address Generator

This block produces one memory address per clock from a bank of pointer registers. Each request names an addressing mode. In direct mode the address is the immediate constant supplied with the request. In indirect mode the address is the current contents of the selected pointer. The address leaves through a registered output, together with a valid flag.

Any pointer can be advanced in the same cycle by a post-increment of a given step. The update wraps inside a circular window. Each pointer keeps its own window base and window length, so a pointer can walk a circular buffer without software checking its bounds. When the request and the increment name the same pointer, the address uses the value from before the increment, and the pointer holds the incremented value from the next cycle on.

Pointers, bases and lengths are written only through a dedicated load port. Nothing on the data path can read or write them.

Top module: `agu_ptr_gen`

## Requirements
- R1: After reset, `addr_vld_o` is 0 and every pointer, base and length is 0, so an indirect request to any pointer returns address 0.
- R2: `addr_vld_o` is 1 exactly in the cycle after a cycle with `acc_en_i`=1, and `addr_o` is registered with the same one-cycle latency.
- R3: When `acc_mode_i`=0 (direct), `addr_o` equals the `acc_imm_i` presented with the request.
- R4: When `acc_mode_i`=1 (indirect), `addr_o` equals the selected pointer's value before any update made in the same cycle.
- R5: When `inc_en_i`=1 and the window length is nonzero, the pointer at `inc_sel_i` becomes base + ((pointer - base + step) mod length). This assumes the step is below the length and the pointer lies inside its window. A sum that equals the length wraps to the base.
- R6: When a pointer's window length is 0, its post-increment is a plain addition that wraps modulo 2^ADDR_W.
- R7: A post-increment with step 0 leaves every pointer unchanged.
- R8: When `ld_en_i`=1, the pointer, base and length at `ld_sel_i` take `ld_ptr_i`, `ld_base_i` and `ld_len_i`, and an indirect request in the next cycle sees the new pointer.
- R9: A load and a post-increment of the same pointer in the same cycle leave the loaded value. A request in that cycle still sees the old value.
- R10: A load or a post-increment changes only the pointer it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en_i | input | 1 | Address request this cycle |
| acc_mode_i | input | 1 | 0 = direct (immediate), 1 = indirect (pointer) |
| acc_sel_i | input | SEL_W (3) | Pointer read by an indirect request |
| acc_imm_i | input | ADDR_W (16) | Immediate address for direct mode |
| inc_en_i | input | 1 | Post-increment a pointer this cycle |
| inc_sel_i | input | SEL_W (3) | Pointer to increment |
| inc_step_i | input | ADDR_W (16) | Increment step |
| ld_en_i | input | 1 | Load a pointer entry |
| ld_sel_i | input | SEL_W (3) | Entry to load |
| ld_ptr_i | input | ADDR_W (16) | New pointer value |
| ld_base_i | input | ADDR_W (16) | New window base |
| ld_len_i | input | ADDR_W (16) | New window length (0 = no window) |
| addr_o | output | ADDR_W (16) | Generated address |
| addr_vld_o | output | 1 | Address valid |

## Verification
An address and its valid flag are due one clock edge after the request. A load or a post-increment is visible to an indirect request made in the next cycle, so its effect reaches `addr_o` two edges after the update. The bench changes inputs on the falling edge and samples `addr_o` on the falling edge that follows the request. Every pointer value it expects comes from a shadow model of the bank that the bench keeps itself, updated with the same priority rules.

// File: rtl/agu_pkg.sv
// Package: shared mode encoding and defaults for the pointer-bank
// address generator. Assumes nothing beyond IEEE 1800-2017.
package agu_pkg;

    typedef enum logic {
        AM_IMMEDIATE = 1'b0,
        AM_POINTER   = 1'b1
    } agu_mode_e;

    localparam int unsigned AGU_DEF_PTRS   = 8;
    localparam int unsigned AGU_DEF_ADDR_W = 16;

endpackage

// File: rtl/agu_wrap_add.sv
// agu_wrap_add: combinational circular-window adder.
// Computes base + ((ptr - base + step) mod len) for a nonzero len, or a
// plain ptr + step when len is 0. Assumes step < len and that ptr lies
// inside [base, base+len) whenever len is nonzero.
module agu_wrap_add #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] len_i,
    input  logic [ADDR_W-1:0] step_i,
    output logic [ADDR_W-1:0] nxt_o
);

    localparam int unsigned SUM_W = ADDR_W + 1;

    logic [ADDR_W-1:0] offset;
    logic [SUM_W-1:0]  raw_sum;
    logic [SUM_W-1:0]  folded;
    logic              over;

    // Offset within the window and the unfolded sum, one bit wider
    always_comb begin
        offset  = ptr_i - base_i;
        raw_sum = {1'b0, offset} + {1'b0, step_i};
        over    = (raw_sum >= {1'b0, len_i});
        folded  = over ? (raw_sum - {1'b0, len_i}) : raw_sum;
    end

    // Pick the linear or windowed result
    always_comb begin
        if (len_i == '0) begin
            nxt_o = ptr_i + step_i;
        end else begin
            nxt_o = base_i + folded[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/agu_ptr_bank.sv
// agu_ptr_bank: NUM_PTRS entries of {pointer, base, length}.
// A load writes all three fields of one entry. An increment writes only
// the pointer of one entry, taking the value computed outside. A load
// wins over an increment of the same entry. Synchronous active-low reset.
module agu_ptr_bank #(
    parameter int unsigned NUM_PTRS = 8,
    parameter int unsigned ADDR_W   = 16,
    localparam int unsigned SEL_W   = $clog2(NUM_PTRS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_en_i,
    input  logic [SEL_W-1:0]               ld_sel_i,
    input  logic [ADDR_W-1:0]              ld_ptr_i,
    input  logic [ADDR_W-1:0]              ld_base_i,
    input  logic [ADDR_W-1:0]              ld_len_i,
    input  logic                           inc_en_i,
    input  logic [SEL_W-1:0]               inc_sel_i,
    input  logic [ADDR_W-1:0]              inc_val_i,
    output logic [NUM_PTRS-1:0][ADDR_W-1:0] ptr_o,
    output logic [NUM_PTRS-1:0][ADDR_W-1:0] base_o,
    output logic [NUM_PTRS-1:0][ADDR_W-1:0] len_o
);

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_entry
        logic hit_ld;
        logic hit_inc;

        // Decode which write port addresses this entry
        always_comb begin
            hit_ld  = ld_en_i  && (ld_sel_i  == SEL_W'(g));
            hit_inc = inc_en_i && (inc_sel_i == SEL_W'(g));
        end

        // Pointer register: load first, then increment
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_o[g] <= '0;
            end else if (hit_ld) begin
                ptr_o[g] <= ld_ptr_i;
            end else if (hit_inc) begin
                ptr_o[g] <= inc_val_i;
            end
        end

        // Window base and length registers, written only by a load
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[g] <= '0;
                len_o[g]  <= '0;
            end else if (hit_ld) begin
                base_o[g] <= ld_base_i;
                len_o[g]  <= ld_len_i;
            end
        end
    end

endmodule

// File: rtl/agu_addr_out.sv
// agu_addr_out: chooses the immediate or the selected pointer and
// registers the address with its valid flag. It reads the bank before
// the edge, so a same-cycle update is not seen. Synchronous active-low reset.
module agu_addr_out
    import agu_pkg::*;
#(
    parameter int unsigned NUM_PTRS = 8,
    parameter int unsigned ADDR_W   = 16,
    localparam int unsigned SEL_W   = $clog2(NUM_PTRS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            acc_en_i,
    input  agu_mode_e                       acc_mode_i,
    input  logic [SEL_W-1:0]                acc_sel_i,
    input  logic [ADDR_W-1:0]               acc_imm_i,
    input  logic [NUM_PTRS-1:0][ADDR_W-1:0] ptr_i,
    output logic [ADDR_W-1:0]               addr_o,
    output logic                            addr_vld_o
);

    logic [ADDR_W-1:0] addr_d;

    // Source select between the immediate and the pointer
    always_comb begin
        addr_d = (acc_mode_i == AM_POINTER) ? ptr_i[acc_sel_i] : acc_imm_i;
    end

    // Output register, updated only when a request is present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o     <= '0;
            addr_vld_o <= 1'b0;
        end else begin
            addr_vld_o <= acc_en_i;
            if (acc_en_i) begin
                addr_o <= addr_d;
            end
        end
    end

endmodule

// File: rtl/agu_ptr_gen.sv
// agu_ptr_gen: top of the pointer-bank address generator.
// One shared windowed adder serves the single increment port. The bank
// stores the entries and the output stage issues the address. Assumes the
// increment step is below the window length of the targeted pointer.
module agu_ptr_gen
    import agu_pkg::*;
#(
    parameter int unsigned NUM_PTRS = AGU_DEF_PTRS,
    parameter int unsigned ADDR_W   = AGU_DEF_ADDR_W,
    localparam int unsigned SEL_W   = $clog2(NUM_PTRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en_i,
    input  logic              acc_mode_i,
    input  logic [SEL_W-1:0]  acc_sel_i,
    input  logic [ADDR_W-1:0] acc_imm_i,
    input  logic              inc_en_i,
    input  logic [SEL_W-1:0]  inc_sel_i,
    input  logic [ADDR_W-1:0] inc_step_i,
    input  logic              ld_en_i,
    input  logic [SEL_W-1:0]  ld_sel_i,
    input  logic [ADDR_W-1:0] ld_ptr_i,
    input  logic [ADDR_W-1:0] ld_base_i,
    input  logic [ADDR_W-1:0] ld_len_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o
);

    logic [NUM_PTRS-1:0][ADDR_W-1:0] ptr_vec;
    logic [NUM_PTRS-1:0][ADDR_W-1:0] base_vec;
    logic [NUM_PTRS-1:0][ADDR_W-1:0] len_vec;
    logic [ADDR_W-1:0]               inc_val;
    agu_mode_e                       mode_e;

    // Cast the raw mode pin onto the package encoding
    always_comb begin
        mode_e = agu_mode_e'(acc_mode_i);
    end

    agu_wrap_add #(
        .ADDR_W (ADDR_W)
    ) u_wrap (
        .ptr_i  (ptr_vec[inc_sel_i]),
        .base_i (base_vec[inc_sel_i]),
        .len_i  (len_vec[inc_sel_i]),
        .step_i (inc_step_i),
        .nxt_o  (inc_val)
    );

    agu_ptr_bank #(
        .NUM_PTRS (NUM_PTRS),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en_i   (ld_en_i),
        .ld_sel_i  (ld_sel_i),
        .ld_ptr_i  (ld_ptr_i),
        .ld_base_i (ld_base_i),
        .ld_len_i  (ld_len_i),
        .inc_en_i  (inc_en_i),
        .inc_sel_i (inc_sel_i),
        .inc_val_i (inc_val),
        .ptr_o     (ptr_vec),
        .base_o    (base_vec),
        .len_o     (len_vec)
    );

    agu_addr_out #(
        .NUM_PTRS (NUM_PTRS),
        .ADDR_W   (ADDR_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en_i   (acc_en_i),
        .acc_mode_i (mode_e),
        .acc_sel_i  (acc_sel_i),
        .acc_imm_i  (acc_imm_i),
        .ptr_i      (ptr_vec),
        .addr_o     (addr_o),
        .addr_vld_o (addr_vld_o)
    );

endmodule

// File: rtl/agu_ptr_gen_chk.sv
// agu_ptr_gen_chk: temporal properties of agu_ptr_gen, attached by bind.
// It observes the ports and the pointer vector of the bank.
module agu_ptr_gen_chk #(
    parameter int unsigned NUM_PTRS = 8,
    parameter int unsigned ADDR_W   = 16,
    localparam int unsigned SEL_W   = $clog2(NUM_PTRS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            acc_en_i,
    input logic                            acc_mode_i,
    input logic [SEL_W-1:0]                acc_sel_i,
    input logic [ADDR_W-1:0]               acc_imm_i,
    input logic                            inc_en_i,
    input logic [ADDR_W-1:0]               inc_step_i,
    input logic                            ld_en_i,
    input logic [SEL_W-1:0]                ld_sel_i,
    input logic [ADDR_W-1:0]               ld_ptr_i,
    input logic [NUM_PTRS-1:0][ADDR_W-1:0] ptr_vec,
    input logic [ADDR_W-1:0]               addr_o,
    input logic                            addr_vld_o
);

    // R2: valid follows the request by exactly one cycle
    p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en_i |=> addr_vld_o);
    p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en_i |=> !addr_vld_o);

    // R3: a direct request returns its immediate
    p_direct_imm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_mode_i) |=> (addr_o == $past(acc_imm_i)));

    // R4: an indirect request returns the pointer value before the edge
    p_indirect_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && acc_mode_i) |=> (addr_o == $past(ptr_vec[acc_sel_i])));

    // R7: a zero step with no load leaves the whole bank untouched
    p_zero_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en_i && (inc_step_i == '0) && !ld_en_i) |=> (ptr_vec == $past(ptr_vec)));

    // R8: a load lands in the selected pointer
    p_load_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en_i |=> (ptr_vec[$past(ld_sel_i)] == $past(ld_ptr_i)));

endmodule

bind agu_ptr_gen agu_ptr_gen_chk #(
    .NUM_PTRS (NUM_PTRS),
    .ADDR_W   (ADDR_W)
) u_agu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en_i   (acc_en_i),
    .acc_mode_i (acc_mode_i),
    .acc_sel_i  (acc_sel_i),
    .acc_imm_i  (acc_imm_i),
    .inc_en_i   (inc_en_i),
    .inc_step_i (inc_step_i),
    .ld_en_i    (ld_en_i),
    .ld_sel_i   (ld_sel_i),
    .ld_ptr_i   (ld_ptr_i),
    .ptr_vec    (ptr_vec),
    .addr_o     (addr_o),
    .addr_vld_o (addr_vld_o)
);

// File: tb/agu_ptr_gen_tb_top.sv
// agu_ptr_gen_tb_top: directed bench, one task per scenario. It drives on
// the falling edge and samples on the next falling edge.
module agu_ptr_gen_tb_top;

    localparam int unsigned NP = 8;
    localparam int unsigned AW = 16;
    localparam int unsigned SW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          acc_en, acc_mode, inc_en, ld_en;
    logic [SW-1:0] acc_sel, inc_sel, ld_sel;
    logic [AW-1:0] acc_imm, inc_step, ld_ptr, ld_base, ld_len;
    logic [AW-1:0] addr;
    logic          vld;

    int n_chk  = 0;
    int n_fail = 0;

    logic [AW-1:0] m_ptr  [NP];
    logic [AW-1:0] m_base [NP];
    logic [AW-1:0] m_len  [NP];

    always #5 clk = ~clk;

    agu_ptr_gen #(.NUM_PTRS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_en_i(acc_en), .acc_mode_i(acc_mode), .acc_sel_i(acc_sel), .acc_imm_i(acc_imm),
        .inc_en_i(inc_en), .inc_sel_i(inc_sel), .inc_step_i(inc_step),
        .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_ptr_i(ld_ptr), .ld_base_i(ld_base), .ld_len_i(ld_len),
        .addr_o(addr), .addr_vld_o(vld)
    );

    function automatic logic [AW-1:0] model_next(input int k, input logic [AW-1:0] st);
        int unsigned off;
        int unsigned s;
        if (m_len[k] == 0) return m_ptr[k] + st;
        off = int'(AW'(m_ptr[k] - m_base[k]));
        s   = (off + int'(st)) % int'(m_len[k]);
        return m_base[k] + AW'(s);
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_en = 0; acc_mode = 0; acc_sel = '0; acc_imm = '0;
        inc_en = 0; inc_sel = '0; inc_step = '0;
        ld_en = 0; ld_sel = '0; ld_ptr = '0; ld_base = '0; ld_len = '0;
    endtask

    task automatic load(input int k, input logic [AW-1:0] p, b, l);
        ld_en = 1; ld_sel = SW'(k); ld_ptr = p; ld_base = b; ld_len = l;
        @(negedge clk);
        ld_en = 0;
        m_ptr[k] = p; m_base[k] = b; m_len[k] = l;
    endtask

    task automatic read_ptr(input int k, output logic [AW-1:0] v);
        acc_en = 1; acc_mode = 1; acc_sel = SW'(k);
        @(negedge clk);
        v = addr;
        acc_en = 0;
    endtask

    // R1: reset state
    task automatic t_reset();
        logic [AW-1:0] v;
        check("R1 vld after reset", AW'(vld), '0);
        for (int k = 0; k < NP; k++) begin
            read_ptr(k, v);
            check("R1 pointer zero", v, '0);
        end
    endtask

    // R2/R3: direct request and valid timing
    task automatic t_direct();
        acc_en = 1; acc_mode = 0; acc_imm = 16'h1234;
        @(negedge clk);
        check("R3 direct addr", addr, 16'h1234);
        check("R2 vld high", AW'(vld), 1);
        acc_imm = 16'hBEEF;
        @(negedge clk);
        check("R3 direct addr back-to-back", addr, 16'hBEEF);
        acc_en = 0;
        @(negedge clk);
        check("R2 vld low after idle", AW'(vld), 0);
    endtask

    // R8/R4/R5: load, then access with same-cycle post-increment and wrap
    task automatic t_window();
        logic [AW-1:0] v;
        load(2, 16'h0105, 16'h0100, 16'd8);
        read_ptr(2, v);
        check("R8 loaded pointer", v, 16'h0105);
        acc_en = 1; acc_mode = 1; acc_sel = 2;
        inc_en = 1; inc_sel = 2; inc_step = 16'd2;
        @(negedge clk);
        check("R4 access sees old value", addr, 16'h0105);
        m_ptr[2] = model_next(2, 16'd2);
        inc_en = 0; acc_en = 0;
        read_ptr(2, v);
        check("R5 post-increment", v, m_ptr[2]);
        inc_en = 1; inc_sel = 2; inc_step = 16'd3;
        @(negedge clk);
        m_ptr[2] = model_next(2, 16'd3);
        inc_en = 0;
        read_ptr(2, v);
        check("R5 wrap past end", v, m_ptr[2]);
        check("R5 wrap value", v, 16'h0102);
        load(2, 16'h0107, 16'h0100, 16'd8);
        inc_en = 1; inc_sel = 2; inc_step = 16'd1;
        @(negedge clk);
        m_ptr[2] = model_next(2, 16'd1);
        inc_en = 0;
        read_ptr(2, v);
        check("R5 sum equal to length wraps to base", v, 16'h0100);
    endtask

    // R6: zero length means plain modulo-2^AW add
    task automatic t_linear();
        logic [AW-1:0] v;
        load(5, 16'hFFFE, 16'h0000, 16'd0);
        inc_en = 1; inc_sel = 5; inc_step = 16'd5;
        @(negedge clk);
        inc_en = 0;
        read_ptr(5, v);
        check("R6 linear wrap", v, 16'h0003);
        m_ptr[5] = 16'h0003;
    endtask

    // R7: zero step
    task automatic t_zero_step();
        logic [AW-1:0] v;
        inc_en = 1; inc_sel = 2; inc_step = '0;
        @(negedge clk);
        inc_en = 0;
        read_ptr(2, v);
        check("R7 zero step", v, m_ptr[2]);
    endtask

    // R9: load beats increment on the same pointer
    task automatic t_priority();
        logic [AW-1:0] v;
        acc_en = 1; acc_mode = 1; acc_sel = 2;
        inc_en = 1; inc_sel = 2; inc_step = 16'd1;
        ld_en = 1; ld_sel = 2; ld_ptr = 16'h0204; ld_base = 16'h0200; ld_len = 16'd16;
        @(negedge clk);
        check("R9 access in load cycle sees old", addr, m_ptr[2]);
        idle();
        m_ptr[2] = 16'h0204; m_base[2] = 16'h0200; m_len[2] = 16'd16;
        read_ptr(2, v);
        check("R9 load wins", v, 16'h0204);
    endtask

    // R10: other pointers untouched
    task automatic t_isolation();
        logic [AW-1:0] v;
        inc_en = 1; inc_sel = 2; inc_step = 16'd4;
        @(negedge clk);
        inc_en = 0;
        m_ptr[2] = model_next(2, 16'd4);
        read_ptr(5, v);
        check("R10 pointer 5 untouched", v, m_ptr[5]);
        read_ptr(0, v);
        check("R10 pointer 0 untouched", v, m_ptr[0]);
        read_ptr(2, v);
        check("R10 pointer 2 advanced", v, m_ptr[2]);
    endtask

    initial begin
        for (int k = 0; k < NP; k++) begin
            m_ptr[k] = '0; m_base[k] = '0; m_len[k] = '0;
        end
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_window();
        t_linear();
        t_zero_step();
        t_priority();
        t_isolation();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule